// File: doc/BRIEF.md
# Prioritized Interrupt Entry Sequencer

This block runs the entry half of exception handling for an 8-bit processor core with a 16-bit address space. Request pulses on four lines (reset, non-maskable, fast and normal interrupt) are latched as pending. At each instruction boundary, the core strobes the block and presents its current register file. The block then chooses the most urgent request that its mask bits allow. It updates the condition-code byte and pushes either the whole register set or a short frame onto the system stack, one byte per cycle. Last, it fetches the handler address from that source's vector through a byte read port.

When the sequence ends, a one-cycle `done` strobe marks the updated condition codes, direct page, stack pointer and program counter as valid. The core copies them back into its register file. The accumulators and index registers are only read, never modified. A boundary strobe that arrives while a sequence is running is ignored.

Condition-code bit positions used throughout: bit 7 is E (entire state saved), bit 6 is F (fast-interrupt mask), bit 4 is I (normal-interrupt mask).

Top module: `int_entry_seq`

## Requirements
- R1: After reset the block is idle: `busy`, `done`, `mem_we` and `mem_re` are all low, no request is pending, and a boundary strobe with nothing pending causes no memory activity.
- R2: At a boundary the block takes one request only, in this fixed order: reset, then non-maskable, then fast (only when F=0), then normal (only when I=0). Requests that are not taken stay pending. `src_out` reports the source taken: 0 reset, 1 non-maskable, 2 fast, 3 normal.
- R3: Reset entry writes nothing to the stack. It ORs 0x50 into CC, clears DP, leaves S unchanged, and loads PC from the bytes at 0xFFFE (high) and 0xFFFF (low).
- R4: Non-maskable entry first sets E. It then pushes 12 bytes, each at a pre-decremented S, in this order: PC low, PC high, U low, U high, Y low, Y high, X low, X high, DP, B, A, and CC (with the new E). After the pushes it sets F and I and loads PC from vector 0xFFFC.
- R5: Fast entry first clears E. It then pushes only PC low, PC high and CC (with the cleared E) at pre-decremented S. After the pushes it sets F and I and loads PC from vector 0xFFF6.
- R6: Normal entry first sets E and pushes the same 12-byte frame as R4. After the pushes it sets I, leaves F unchanged, and loads PC from vector 0xFFF8.
- R7: A fast or normal request whose mask bit is set produces no memory activity and no `done`. It stays pending and is taken at a later boundary where its mask is clear.
- R8: Requests are acted on only at a boundary strobe while idle. A request with no boundary does nothing. A boundary strobe during a running sequence is ignored, and a request arriving during the sequence is taken at a later boundary.
- R9: Each vector is read big-endian: the byte at the vector address is read first and becomes PC[15:8], then the byte at the address plus one becomes PC[7:0]. Read data returns one cycle after `mem_re`.
- R10: `mem_we` and `mem_re` are never high together. `done` pulses for one cycle after the second vector read, and the outputs hold the final values in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_reset | input | 1 | Reset request pulse |
| req_nmi | input | 1 | Non-maskable request pulse |
| req_firq | input | 1 | Fast interrupt request pulse |
| req_irq | input | 1 | Normal interrupt request pulse |
| boundary | input | 1 | Instruction-boundary strobe |
| cc_in | input | 8 | Current condition codes |
| a_in | input | 8 | Accumulator A |
| b_in | input | 8 | Accumulator B |
| dp_in | input | 8 | Direct-page register |
| x_in | input | 16 | Index X |
| y_in | input | 16 | Index Y |
| u_in | input | 16 | User stack pointer |
| s_in | input | 16 | System stack pointer |
| pc_in | input | 16 | Program counter (return address) |
| mem_we | output | 1 | Stack byte write strobe |
| mem_waddr | output | 16 | Write address |
| mem_wdata | output | 8 | Write data |
| mem_re | output | 1 | Vector byte read strobe |
| mem_raddr | output | 16 | Read address |
| mem_rdata | input | 8 | Read data, one cycle after `mem_re` |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion strobe |
| src_out | output | 2 | Source taken |
| cc_out | output | 8 | Updated condition codes |
| dp_out | output | 8 | Updated direct page |
| s_out | output | 16 | Updated system stack pointer |
| pc_out | output | 16 | Handler address |

## Verification
The bench pulses all four request lines at once. A design with a wrong priority order, or one that clears every pending request on entry, would take the wrong source or fail to take the non-maskable request at the next boundary.

With F set and I clear, the bench raises both the fast and the normal request. A design that ignores the masks would take the fast request. Later the fast request is unmasked, and a design that dropped it while masked would show no sequence at all.

Every stacked byte is checked by address and value. This catches a post-decrement stack, a swapped byte order, a CC byte pushed before E changes, and a design that sets F on normal entry.

Finally, the bench raises a boundary strobe and a new request in the middle of a sequence. A design that restarted on that strobe would emit stack writes the bench does not expect.

// File: rtl/int_entry_seq.sv
module int_entry_seq #(
  parameter logic [15:0] VEC_RESET = 16'hFFFE,
  parameter logic [15:0] VEC_NMI   = 16'hFFFC,
  parameter logic [15:0] VEC_FIRQ  = 16'hFFF6,
  parameter logic [15:0] VEC_IRQ   = 16'hFFF8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_reset,
  input  logic        req_nmi,
  input  logic        req_firq,
  input  logic        req_irq,
  input  logic        boundary,
  input  logic [7:0]  cc_in,
  input  logic [7:0]  a_in,
  input  logic [7:0]  b_in,
  input  logic [7:0]  dp_in,
  input  logic [15:0] x_in,
  input  logic [15:0] y_in,
  input  logic [15:0] u_in,
  input  logic [15:0] s_in,
  input  logic [15:0] pc_in,
  output logic        mem_we,
  output logic [15:0] mem_waddr,
  output logic [7:0]  mem_wdata,
  output logic        mem_re,
  output logic [15:0] mem_raddr,
  input  logic [7:0]  mem_rdata,
  output logic        busy,
  output logic        done,
  output logic [1:0]  src_out,
  output logic [7:0]  cc_out,
  output logic [7:0]  dp_out,
  output logic [15:0] s_out,
  output logic [15:0] pc_out
);
  localparam logic [1:0] SRC_RST  = 2'd0;
  localparam logic [1:0] SRC_NMI  = 2'd1;
  localparam logic [1:0] SRC_FIRQ = 2'd2;
  localparam logic [1:0] SRC_IRQ  = 2'd3;
  localparam int         FULL_LAST  = 11;
  localparam int         SHORT_LAST = 2;
  localparam logic [7:0] FLG_E = 8'h80;
  localparam logic [7:0] FLG_F = 8'h40;
  localparam logic [7:0] FLG_I = 8'h10;

  typedef enum logic [2:0] {S_IDLE, S_PUSH, S_RD0, S_RD1, S_RD2, S_FIN} st_t;

  st_t         st;
  logic [3:0]  pend;
  logic [1:0]  src_r;
  logic [3:0]  cnt;
  logic [7:0]  cc_r, dp_r, a_r, b_r, hi_r;
  logic [15:0] s_r, pc_r, x_r, y_r, u_r;

  logic firq_ok, irq_ok, take;
  logic [1:0] src_n;
  logic [3:0] clr;
  logic [3:0] idx;
  logic       last;
  logic [15:0] vec;

  assign firq_ok = pend[1] && !cc_in[6];
  assign irq_ok  = pend[0] && !cc_in[4];
  assign take    = boundary && (st == S_IDLE) && (pend[3] || pend[2] || firq_ok || irq_ok);

  always_comb begin
    if (pend[3])      src_n = SRC_RST;
    else if (pend[2]) src_n = SRC_NMI;
    else if (firq_ok) src_n = SRC_FIRQ;
    else              src_n = SRC_IRQ;
  end

  always_comb begin
    clr = 4'b0000;
    if (take) clr[3 - src_n] = 1'b1;
  end

  always_comb begin
    case (src_r)
      SRC_RST:  vec = VEC_RESET;
      SRC_NMI:  vec = VEC_NMI;
      SRC_FIRQ: vec = VEC_FIRQ;
      default:  vec = VEC_IRQ;
    endcase
  end

  assign idx  = (src_r == SRC_FIRQ && cnt == SHORT_LAST[3:0]) ? FULL_LAST[3:0] : cnt;
  assign last = (src_r == SRC_FIRQ) ? (cnt == SHORT_LAST[3:0]) : (cnt == FULL_LAST[3:0]);

  always_comb begin
    case (idx)
      4'd0:    mem_wdata = pc_r[7:0];
      4'd1:    mem_wdata = pc_r[15:8];
      4'd2:    mem_wdata = u_r[7:0];
      4'd3:    mem_wdata = u_r[15:8];
      4'd4:    mem_wdata = y_r[7:0];
      4'd5:    mem_wdata = y_r[15:8];
      4'd6:    mem_wdata = x_r[7:0];
      4'd7:    mem_wdata = x_r[15:8];
      4'd8:    mem_wdata = dp_r;
      4'd9:    mem_wdata = b_r;
      4'd10:   mem_wdata = a_r;
      default: mem_wdata = cc_r;
    endcase
  end

  assign mem_we    = (st == S_PUSH);
  assign mem_waddr = s_r - 16'd1;
  assign mem_re    = (st == S_RD0) || (st == S_RD1);
  assign mem_raddr = (st == S_RD1) ? vec + 16'd1 : vec;
  assign busy      = (st != S_IDLE);
  assign done      = (st == S_FIN);
  assign src_out   = src_r;
  assign cc_out    = cc_r;
  assign dp_out    = dp_r;
  assign s_out     = s_r;
  assign pc_out    = pc_r;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; pend <= '0; src_r <= SRC_RST; cnt <= '0;
      cc_r <= '0; dp_r <= '0; a_r <= '0; b_r <= '0; hi_r <= '0;
      s_r <= '0; pc_r <= '0; x_r <= '0; y_r <= '0; u_r <= '0;
    end else begin
      pend <= (pend & ~clr) | {req_reset, req_nmi, req_firq, req_irq};
      case (st)
        S_IDLE: if (take) begin
          src_r <= src_n;
          cnt   <= '0;
          a_r <= a_in; b_r <= b_in; x_r <= x_in; y_r <= y_in; u_r <= u_in;
          s_r <= s_in; pc_r <= pc_in;
          dp_r <= (src_n == SRC_RST) ? 8'h00 : dp_in;
          case (src_n)
            SRC_RST:  cc_r <= cc_in | FLG_F | FLG_I;
            SRC_FIRQ: cc_r <= cc_in & ~FLG_E;
            default:  cc_r <= cc_in | FLG_E;
          endcase
          st <= (src_n == SRC_RST) ? S_RD0 : S_PUSH;
        end
        S_PUSH: begin
          s_r <= s_r - 16'd1;
          cnt <= cnt + 4'd1;
          if (last) begin
            cc_r <= cc_r | FLG_I | ((src_r == SRC_IRQ) ? 8'h00 : FLG_F);
            st   <= S_RD0;
          end
        end
        S_RD0: st <= S_RD1;
        S_RD1: begin hi_r <= mem_rdata; st <= S_RD2; end
        S_RD2: begin pc_r <= {hi_r, mem_rdata}; st <= S_FIN; end
        default: st <= S_IDLE;
      endcase
    end
  end

  a_r10_excl: assert property (@(posedge clk) disable iff (!rst_n) !(mem_we && mem_re));
  a_r4_predec: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && $past(mem_we)) |-> (mem_waddr == $past(mem_waddr) - 16'd1));
  a_r9_order: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_re && $past(mem_re)) |-> (mem_raddr == $past(mem_raddr) + 16'd1));
  a_r3_reset_regs: assert property (@(posedge clk) disable iff (!rst_n)
    (done && src_out == SRC_RST) |-> (dp_out == 8'h00 && cc_out[6] && cc_out[4]));
  a_r5_firq_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (done && src_out == SRC_FIRQ) |-> (!cc_out[7] && cc_out[6] && cc_out[4]));
  a_r6_irq_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (done && src_out == SRC_IRQ) |-> (cc_out[7] && cc_out[4]));
  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

// File: tb/tb_int_entry_seq.sv
module tb_int_entry_seq;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_reset = 0, req_nmi = 0, req_firq = 0, req_irq = 0, boundary = 0;
  logic [7:0]  cc_in = 0, a_in = 0, b_in = 0, dp_in = 0;
  logic [15:0] x_in = 0, y_in = 0, u_in = 0, s_in = 0, pc_in = 0;
  logic        mem_we, mem_re, busy, done;
  logic [15:0] mem_waddr, mem_raddr, s_out, pc_out;
  logic [7:0]  mem_wdata, mem_rdata, cc_out, dp_out;
  logic [1:0]  src_out;

  always #2 clk = ~clk;

  int_entry_seq dut (
    .clk(clk), .rst_n(rst_n), .req_reset(req_reset), .req_nmi(req_nmi),
    .req_firq(req_firq), .req_irq(req_irq), .boundary(boundary),
    .cc_in(cc_in), .a_in(a_in), .b_in(b_in), .dp_in(dp_in),
    .x_in(x_in), .y_in(y_in), .u_in(u_in), .s_in(s_in), .pc_in(pc_in),
    .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata),
    .mem_re(mem_re), .mem_raddr(mem_raddr), .mem_rdata(mem_rdata),
    .busy(busy), .done(done), .src_out(src_out), .cc_out(cc_out),
    .dp_out(dp_out), .s_out(s_out), .pc_out(pc_out));

  function automatic logic [7:0] vbyte(input logic [15:0] a);
    return a[7:0] ^ 8'h3C ^ {a[11:8], a[15:12]};
  endfunction

  always_ff @(posedge clk) if (mem_re) mem_rdata <= vbyte(mem_raddr);

  int total = 0, bad = 0;
  string tag = "R1";
  logic [23:0] qw[$];
  logic [15:0] qr[$];
  logic [57:0] qd[$];
  bit fin_flag = 0;

  task automatic chk(input bit ok, input string t, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", t, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    if (mem_we) begin
      if (qw.size() == 0) chk(0, {tag, " unexpected write"}, {mem_waddr, mem_wdata}, 0);
      else begin
        logic [23:0] e;
        e = qw.pop_front();
        chk({mem_waddr, mem_wdata} == e, {tag, " stack write"}, {mem_waddr, mem_wdata}, e);
      end
    end
    if (mem_re) begin
      if (qr.size() == 0) chk(0, {tag, " unexpected read"}, mem_raddr, 0);
      else begin
        logic [15:0] e;
        e = qr.pop_front();
        chk(mem_raddr == e, {tag, " R9 vector read"}, mem_raddr, e);
      end
    end
    if (done) begin
      if (qd.size() == 0) chk(0, {tag, " unexpected done"}, 0, 0);
      else begin
        logic [57:0] e;
        e = qd.pop_front();
        chk({src_out, cc_out, dp_out, s_out, pc_out} == e, {tag, " final regs"},
            {src_out, cc_out, dp_out, s_out, pc_out}, e);
      end
      fin_flag = 1;
    end
  end

  task automatic expect_entry(input logic [1:0] src);
    logic [7:0]  cc1, ccf, dpf;
    logic [15:0] s, vec, pcn;
    logic [7:0]  fr[12];
    int n;
    fr = '{pc_in[7:0], pc_in[15:8], u_in[7:0], u_in[15:8], y_in[7:0], y_in[15:8],
           x_in[7:0], x_in[15:8], dp_in, b_in, a_in, 8'h00};
    s = s_in; dpf = dp_in;
    case (src)
      2'd0: begin vec = 16'hFFFE; ccf = cc_in | 8'h50; dpf = 8'h00; n = 0; cc1 = ccf; end
      2'd1: begin vec = 16'hFFFC; cc1 = cc_in | 8'h80; ccf = cc1 | 8'h50; n = 12; end
      2'd2: begin vec = 16'hFFF6; cc1 = cc_in & 8'h7F; ccf = cc1 | 8'h50; n = 3; end
      default: begin vec = 16'hFFF8; cc1 = cc_in | 8'h80; ccf = cc1 | 8'h10; n = 12; end
    endcase
    fr[11] = cc1;
    for (int k = 0; k < n; k++) begin
      int j;
      j = (n == 3 && k == 2) ? 11 : k;
      s = s - 16'd1;
      qw.push_back({s, fr[j]});
    end
    qr.push_back(vec);
    qr.push_back(vec + 16'd1);
    pcn = {vbyte(vec), vbyte(vec + 16'd1)};
    qd.push_back({src, ccf, dpf, s, pcn});
  endtask

  task automatic pulse_bnd();
    @(posedge clk); #1 boundary = 1;
    @(posedge clk); #1 boundary = 0;
  endtask

  task automatic wait_fin();
    while (!fin_flag) @(posedge clk);
    fin_flag = 0;
    @(posedge clk);
  endtask

  task automatic idle_check(input string t, input int cycles);
    repeat (cycles) @(posedge clk);
    @(negedge clk);
    chk(!busy && !done, t, {busy, done}, 0);
  endtask

  task automatic set_regs(input logic [7:0] cc, input logic [15:0] base);
    cc_in = cc; a_in = base[7:0] + 8'h11; b_in = base[7:0] + 8'h22; dp_in = base[15:8];
    x_in = base + 16'h1357; y_in = base + 16'h2468; u_in = base + 16'h3579;
    s_in = base + 16'h0800; pc_in = base + 16'h4ABC;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    tag = "R1";
    chk(!busy && !done && !mem_we && !mem_re, "R1 reset state", {busy, done, mem_we, mem_re}, 0);
    pulse_bnd();
    idle_check("R1 boundary with nothing pending", 5);

    tag = "R2";
    set_regs(8'h00, 16'h1000);
    @(posedge clk); #1 req_reset = 1; req_nmi = 1; req_firq = 1; req_irq = 1;
    @(posedge clk); #1 req_reset = 0; req_nmi = 0; req_firq = 0; req_irq = 0;
    expect_entry(2'd0);
    pulse_bnd(); wait_fin();

    tag = "R4";
    set_regs(8'h0F, 16'h2000);
    expect_entry(2'd1);
    pulse_bnd(); wait_fin();

    tag = "R7";
    set_regs(8'h40, 16'h3000);
    expect_entry(2'd3);
    pulse_bnd(); wait_fin();

    tag = "R7";
    set_regs(8'h50, 16'h3100);
    pulse_bnd();
    idle_check("R7 masked fast request stays quiet", 6);

    tag = "R5";
    set_regs(8'h8A, 16'h4000);
    expect_entry(2'd2);
    pulse_bnd(); wait_fin();

    tag = "R8";
    set_regs(8'h05, 16'h5000);
    @(posedge clk); #1 req_irq = 1;
    @(posedge clk); #1 req_irq = 0;
    idle_check("R8 request without boundary", 6);

    tag = "R6";
    expect_entry(2'd3);
    pulse_bnd();
    repeat (4) @(posedge clk);
    #1 req_nmi = 1; boundary = 1;
    @(posedge clk); #1 req_nmi = 0; boundary = 0;
    wait_fin();
    idle_check("R8 boundary during sequence ignored", 3);

    tag = "R8";
    set_regs(8'h00, 16'h6000);
    expect_entry(2'd1);
    pulse_bnd(); wait_fin();

    tag = "R3";
    set_regs(8'h2A, 16'h7000);
    @(posedge clk); #1 req_reset = 1;
    @(posedge clk); #1 req_reset = 0;
    expect_entry(2'd0);
    pulse_bnd(); wait_fin();

    tag = "R10";
    idle_check("R10 idle after done", 3);
    chk(qw.size() == 0 && qr.size() == 0 && qd.size() == 0, "R10 all expected traffic seen",
        qw.size() + qr.size() + qd.size(), 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog %s actual=hung expected=finished", tag);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule